// File: doc/BRIEF.md
# Event Counter with Switchable Prescaler and Watchdog

This block holds an 8-bit event counter and a watchdog counter. One 8-bit prescaler sits in front of one of them at a time. A 6-bit mode register selects four things: where the counter's events come from (the instruction-cycle tick or an external pin), which pin edge counts, which counter the prescaler divides for, and the division code. The counter value can be read and written through a simple register port. Software keeps the watchdog from expiring by issuing clear or sleep strobes. If it does not, a one-clock time-out pulse appears.

The division code maps to a ratio that depends on the prescaler owner. The same code divides twice as much for the event counter as for the watchdog, so a watchdog ratio of 1:1 is available. Writing the counter restarts the prescaler and ignores the next two instruction cycles, so a freshly loaded value is not advanced at once.

Top module: `cnt_wdg_top`

## Requirements
- R1: After reset the mode readback is 0x3F, the counter reads 0 and the time-out output is low.
- R2: With mode bit 5 = 0 and mode bit 3 = 0, the counter advances once per 2^(c+1) instruction-cycle ticks, where c is mode bits 2:0 (code 0 gives 1:2, code 7 gives 1:256).
- R3: With mode bit 3 = 1, the watchdog counter advances once per 2^c watchdog ticks (code 0 gives 1:1, code 7 gives 1:128), and the event counter advances on every selected event without division.
- R4: With mode bit 5 = 1, the counter steps on pin transitions: rising ones when mode bit 4 = 0, falling ones when mode bit 4 = 1. The pin passes through two synchroniser flops, so a counted transition shows on the counter no more than 4 clocks after the pin changes.
- R5: The source not selected by mode bit 5 has no effect on the counter.
- R6: A counter write loads the written byte, clears the prescaler, and causes the next two instruction-cycle ticks to be ignored for counting.
- R7: A clear-watchdog or sleep strobe zeroes the watchdog counter. It also zeroes the prescaler while the prescaler belongs to the watchdog.
- R8: The time-out output pulses high for exactly one clock after the WDT_W-bit watchdog counter steps from all ones to zero.
- R9: Mode writes store bits 5:0; the readback port returns those six bits with bits 7:6 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWe | input | 1 | Mode register write strobe |
| modeWdata | input | 8 | Mode register write data |
| modeRd | output | 8 | Mode register readback |
| extPin | input | 1 | External count pin, asynchronous |
| cycTick | input | 1 | Instruction-cycle tick, one clock wide |
| wdtTick | input | 1 | Watchdog oscillator tick, one clock wide |
| wdtClr | input | 1 | Clear-watchdog strobe |
| sleepCmd | input | 1 | Sleep strobe |
| cntWe | input | 1 | Counter write strobe |
| cntWdata | input | 8 | Counter write data |
| cntRdata | output | 8 | Counter value |
| wdtTimeout | output | 1 | Watchdog time-out pulse |

## Verification
The assertions assume that every strobe and tick is synchronous to the clock and lasts one cycle. They also assume that only the pin may change without regard to the clock. Under those assumptions the counter can move by at most one step per clock, and a clear always wins over a time-out. The stimulus changes every synchronous input on the falling edge and drives each tick for exactly one cycle. It holds the pin steady for several clocks after each change, so each transition reaches the edge detector as a single event.

// File: rtl/cnt_wdg_pkg.sv
package cnt_wdg_pkg;
  localparam int PSC_W   = 8;
  localparam int RATIO_W = $clog2(PSC_W);
  localparam int MODE_W  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic               tmrEvt;
    logic               wdtEvt;
    logic               pscClr;
    logic               wdgClr;
    logic               cntLoad;
    logic               toWdt;
    logic [RATIO_W-1:0] ratio;
  } ctlStrobes_t;
endpackage

// File: rtl/cnt_wdg_ctrl.sv
module cnt_wdg_ctrl
  import cnt_wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [7:0]        modeWdata,
  output logic [MODE_W-1:0] modeQ,
  input  logic              extPin,
  input  logic              cycTick,
  input  logic              wdtTick,
  input  logic              wdtClr,
  input  logic              sleepCmd,
  input  logic              cntWe,
  output ctlStrobes_t       stb
);
  localparam int SYNC_N = 2;
  localparam logic [1:0] INH_CYC = 2'd2;

  logic [SYNC_N-1:0] pinSync;
  logic              pinLast;
  logic [1:0]        inhCnt;
  logic              pinRise, pinFall, pinEvt, srcEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= '1;
    else if (modeWe) modeQ <= modeWdata[MODE_W-1:0];
  end

  // two-flop synchroniser, then edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync <= '0;
      pinLast <= 1'b0;
    end else begin
      pinSync <= {pinSync[SYNC_N-2:0], extPin};
      pinLast <= pinSync[SYNC_N-1];
    end
  end

  assign pinRise = pinSync[SYNC_N-1] & ~pinLast;
  assign pinFall = ~pinSync[SYNC_N-1] & pinLast;
  assign pinEvt  = modeQ[4] ? pinFall : pinRise;
  assign srcEvt  = modeQ[5] ? pinEvt : cycTick;

  // count inhibit after a counter write, measured in instruction cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inhCnt <= '0;
    else if (cntWe) inhCnt <= INH_CYC;
    else if (cycTick && inhCnt != 2'd0) inhCnt <= inhCnt - 2'd1;
  end

  always_comb begin
    stb.tmrEvt  = srcEvt && (inhCnt == 2'd0) && !cntWe;
    stb.wdtEvt  = wdtTick;
    stb.wdgClr  = wdtClr | sleepCmd;
    stb.toWdt   = modeQ[3];
    stb.pscClr  = cntWe | ((wdtClr | sleepCmd) & modeQ[3]);
    stb.cntLoad = cntWe;
    stb.ratio   = modeQ[RATIO_W-1:0];
  end
endmodule

// File: rtl/cnt_wdg_dp.sv
module cnt_wdg_dp
  import cnt_wdg_pkg::*;
#(
  parameter int WDT_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t stb,
  input  logic [7:0]  cntWdata,
  output logic [7:0]  cntQ,
  output logic        timeout
);
  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] pscMask;
  logic [WDT_W-1:0] wdog;
  logic             pscIn, pscOut, tmrStep, wdgStep;
  int               maskLen;

  // ratio table is one step longer when dividing for the counter
  always_comb begin
    maskLen = int'(stb.ratio) + (stb.toWdt ? 0 : 1);
    for (int i = 0; i < PSC_W; i++) pscMask[i] = (i < maskLen);
  end

  assign pscIn   = stb.toWdt ? stb.wdtEvt : stb.tmrEvt;
  assign pscOut  = pscIn && ((psc & pscMask) == pscMask);
  assign tmrStep = stb.toWdt ? stb.tmrEvt : pscOut;
  assign wdgStep = stb.toWdt ? pscOut : stb.wdtEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psc <= '0;
    else if (stb.pscClr) psc <= '0;
    else if (pscIn) psc <= psc + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else if (stb.cntLoad) cntQ <= cntWdata;
    else if (tmrStep) cntQ <= cntQ + 8'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdog    <= '0;
      timeout <= 1'b0;
    end else if (stb.wdgClr) begin
      wdog    <= '0;
      timeout <= 1'b0;
    end else if (wdgStep) begin
      wdog    <= wdog + 1'b1;
      timeout <= &wdog;
    end else begin
      timeout <= 1'b0;
    end
  end
endmodule

// File: rtl/cnt_wdg_top.sv
module cnt_wdg_top
  import cnt_wdg_pkg::*;
#(
  parameter int WDT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWe,
  input  logic [7:0] modeWdata,
  output logic [7:0] modeRd,
  input  logic       extPin,
  input  logic       cycTick,
  input  logic       wdtTick,
  input  logic       wdtClr,
  input  logic       sleepCmd,
  input  logic       cntWe,
  input  logic [7:0] cntWdata,
  output logic [7:0] cntRdata,
  output logic       wdtTimeout
);
  ctlStrobes_t       stb;
  logic [MODE_W-1:0] modeQ;

  cnt_wdg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWdata(modeWdata),
    .modeQ(modeQ), .extPin(extPin), .cycTick(cycTick), .wdtTick(wdtTick),
    .wdtClr(wdtClr), .sleepCmd(sleepCmd), .cntWe(cntWe), .stb(stb)
  );

  cnt_wdg_dp #(.WDT_W(WDT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntWdata(cntWdata),
    .cntQ(cntRdata), .timeout(wdtTimeout)
  );

  assign modeRd = {{(8-MODE_W){1'b0}}, modeQ};
endmodule

// File: rtl/cnt_wdg_chk.sv
module cnt_wdg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeWe,
  input logic [7:0] modeWdata,
  input logic [7:0] modeRd,
  input logic       wdtClr,
  input logic       sleepCmd,
  input logic       cntWe,
  input logic [7:0] cntWdata,
  input logic [7:0] cntRdata,
  input logic       wdtTimeout
);
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    modeWe |=> modeRd == {2'b00, $past(modeWdata[5:0])}); // R9

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |=> cntRdata == $past(cntWdata)); // R6

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWe && $past(cntWe)) |=> cntRdata == $past(cntRdata)); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !cntWe |=> (cntRdata == $past(cntRdata) || cntRdata == $past(cntRdata) + 8'd1)); // R2

  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wdtTimeout |=> !wdtTimeout); // R8

  AST_CLR_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (wdtClr || sleepCmd) |=> !wdtTimeout); // R7
endmodule

bind cnt_wdg_top cnt_wdg_chk u_chk (
  .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWdata(modeWdata),
  .modeRd(modeRd), .wdtClr(wdtClr), .sleepCmd(sleepCmd), .cntWe(cntWe),
  .cntWdata(cntWdata), .cntRdata(cntRdata), .wdtTimeout(wdtTimeout)
);

// File: tb/cnt_wdg_top_tb.sv
`timescale 1ns/1ps
module cnt_wdg_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWe = 1'b0;
  logic [7:0] modeWdata = '0;
  logic [7:0] modeRd;
  logic       extPin = 1'b0;
  logic       cycTick = 1'b0;
  logic       wdtTick = 1'b0;
  logic       wdtClr = 1'b0;
  logic       sleepCmd = 1'b0;
  logic       cntWe = 1'b0;
  logic [7:0] cntWdata = '0;
  logic [7:0] cntRdata;
  logic       wdtTimeout;

  int checks = 0;
  int errors = 0;
  int toSeen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cnt_wdg_top #(.WDT_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWdata(modeWdata),
    .modeRd(modeRd), .extPin(extPin), .cycTick(cycTick), .wdtTick(wdtTick),
    .wdtClr(wdtClr), .sleepCmd(sleepCmd), .cntWe(cntWe), .cntWdata(cntWdata),
    .cntRdata(cntRdata), .wdtTimeout(wdtTimeout)
  );

  always @(negedge clk) if (rstN && wdtTimeout) toSeen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setMode(input logic [7:0] m);
    @(negedge clk); modeWe = 1'b1; modeWdata = m;
    @(negedge clk); modeWe = 1'b0;
  endtask

  task automatic cycPulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cycTick = 1'b1;
      @(negedge clk); cycTick = 1'b0;
    end
  endtask

  task automatic wdtPulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdtTick = 1'b1;
      @(negedge clk); wdtTick = 1'b0;
    end
  endtask

  task automatic writeCnt(input logic [7:0] v);
    @(negedge clk); cntWe = 1'b1; cntWdata = v;
    @(negedge clk); cntWe = 1'b0;
  endtask

  // write and let the two inhibited instruction cycles pass
  task automatic loadCnt(input logic [7:0] v);
    writeCnt(v);
    cycPulses(2);
  endtask

  task automatic clearWdt(input bit useSleep);
    @(negedge clk); if (useSleep) sleepCmd = 1'b1; else wdtClr = 1'b1;
    @(negedge clk); sleepCmd = 1'b0; wdtClr = 1'b0;
  endtask

  task automatic setPin(input logic v);
    @(negedge clk); extPin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 mode", modeRd, 8'h3F);
    check("R1 counter", cntRdata, 0);
    check("R1 timeout", wdtTimeout, 0);
  endtask

  task automatic t_modeBits();
    setMode(8'hC5);
    check("R9 upper bits dropped", modeRd, 8'h05);
  endtask

  task automatic t_internalDiv();
    int codes[3] = '{0, 2, 7};
    foreach (codes[k]) begin
      setMode(8'(codes[k]));
      loadCnt(8'h00);
      cycPulses((2 << codes[k]) - 1);
      check("R2 before divide", cntRdata, 0);
      cycPulses(1);
      check("R2 after divide", cntRdata, 1);
    end
  endtask

  task automatic t_loadInhibit();
    setMode(8'h08);
    writeCnt(8'h10);
    check("R6 load value", cntRdata, 8'h10);
    cycPulses(2);
    check("R6 two cycles ignored", cntRdata, 8'h10);
    cycPulses(1);
    check("R6 counts after inhibit", cntRdata, 8'h11);
    setMode(8'h01);
    loadCnt(8'h40);
    cycPulses(3);
    loadCnt(8'h40);
    cycPulses(3);
    check("R6 prescaler cleared by write", cntRdata, 8'h40);
    cycPulses(1);
    check("R6 step after four", cntRdata, 8'h41);
  endtask

  task automatic t_pin();
    setMode(8'h28);
    loadCnt(8'h00);
    setPin(1'b1);
    check("R4 rising counted", cntRdata, 1);
    setPin(1'b0);
    check("R4 falling ignored", cntRdata, 1);
    setMode(8'h38);
    setPin(1'b1);
    check("R4 rising ignored", cntRdata, 1);
    setPin(1'b0);
    check("R4 falling counted", cntRdata, 2);
  endtask

  task automatic t_source();
    setMode(8'h28);
    loadCnt(8'h05);
    cycPulses(3);
    check("R5 cycle ticks ignored", cntRdata, 5);
    setMode(8'h08);
    loadCnt(8'h05);
    setPin(1'b1);
    setPin(1'b0);
    check("R5 pin ignored", cntRdata, 5);
  endtask

  task automatic t_wdtDiv();
    int base;
    setMode(8'h0B);
    clearWdt(1'b0);
    base = toSeen;
    wdtPulses(8 * 255);
    check("R3 no timeout before 2048", toSeen - base, 0);
    wdtPulses(8);
    repeat (2) @(negedge clk);
    check("R8 timeout at 2048", toSeen - base, 1);
    loadCnt(8'h00);
    cycPulses(3);
    check("R3 counter undivided", cntRdata, 3);
  endtask

  task automatic t_wdtClear(input bit useSleep);
    int base;
    setMode(8'h08);
    clearWdt(useSleep);
    base = toSeen;
    wdtPulses(200);
    clearWdt(useSleep);
    wdtPulses(255);
    check("R7 clear restarts watchdog", toSeen - base, 0);
    wdtPulses(1);
    repeat (2) @(negedge clk);
    check("R8 timeout after 256", toSeen - base, 1);
  endtask

  task automatic t_pscClear();
    int base;
    setMode(8'h09);
    clearWdt(1'b0);
    wdtPulses(1);
    clearWdt(1'b0);
    base = toSeen;
    wdtPulses(511);
    repeat (2) @(negedge clk);
    check("R7 prescaler cleared", toSeen - base, 0);
    wdtPulses(1);
    repeat (2) @(negedge clk);
    check("R7 timeout on 512th", toSeen - base, 1);
  endtask

  task automatic t_rawWdt();
    int base;
    setMode(8'h00);
    clearWdt(1'b1);
    base = toSeen;
    wdtPulses(256);
    repeat (2) @(negedge clk);
    check("R8 undivided watchdog", toSeen - base, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_modeBits();
    t_internalDiv();
    t_loadInhibit();
    t_pin();
    t_source();
    t_wdtDiv();
    t_wdtClear(1'b0);
    t_wdtClear(1'b1);
    t_pscClear();
    t_rawWdt();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule